// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

The engine moves pixel rectangles inside one shared frame buffer. It runs one of two jobs. A copy moves a source rectangle to a destination rectangle. A fill paints a destination rectangle with one solid colour. The surrounding register block presents the set-up on the input ports: corner coordinates, size, pitches, offsets, two direction bits, the pixel type and a mix word. It then pulses `start` for one cycle. The engine captures the whole set-up at that moment, so later changes on the inputs have no effect on the job already running.

The engine checks the captured set-up in a single cycle. A job that passes the check drives one pixel per memory transaction on a request/ready port. The port carries a byte address and a byte-enable mask, and read data comes back in the cycle that `mem_ready` accepts the read. A copy reads each pixel and then writes it. A fill only writes. When the job ends, the engine updates its destination coordinate outputs so that the next job can continue where this one stopped.

The engine is a five-state machine:
- IDLE waits for `start` (transition *launch*).
- CHECK validates the set-up. From there it takes *abort* to FINISH, *empty* to FINISH, *begin-copy* to READ or *begin-fill* to WRITE.
- READ issues a source read and takes *fetched* to WRITE when the read is accepted.
- WRITE stores one pixel. It takes *next-copy* to READ, *next-fill* to WRITE, or *last* to FINISH.
- FINISH pulses `done` and takes *retire* to IDLE.

Top module: `blit2d_engine`

## Requirements
- R1: `pix_type` selects the pixel size. Code 2 means 1 byte, codes 3 and 4 mean 2 bytes, code 5 means 3 bytes and code 6 means 4 bytes. Every write uses `mem_be` = 0001, 0011, 0111 or 1111 to match, with the pixel in the low bytes of `mem_wdata`. Any other code raises `cfg_error` and the job writes nothing.
- R2: Each axis has its own direction bit. With `x_fwd`=1 the left column is the programmed x. With `x_fwd`=0 the left column is x+1−width. `y_fwd` resolves the top row from y and height the same way. The source corner is resolved from `src_x`/`src_y` by the same rule.
- R3: With `per_surface`=1, the source uses `src_pitch`/`src_base` and the destination uses `dst_pitch`/`dst_base`. With `per_surface`=0, both surfaces use `def_pitch`/`def_base`.
- R4: A destination pitch of zero raises `cfg_error`. A source pitch of zero raises it only for a copy, and a fill ignores the source pitch.
- R5: The job is rejected with `cfg_error` in two cases. One is a resolved corner above 0x3FFF, which includes a reverse-direction corner that would go below zero. The other is base + x + (y + height) × pitch ≥ 2^ADDR_W for either surface in use.
- R6: `mix[23:16]` is the raster code. 0xCC means copy, 0xF0 means brush fill, 0x00 means black fill and 0xFF means white fill. Any other code raises `rop_unsupported` and nothing is written.
- R7: A brush fill writes `brush_color`. A black fill writes {0xFF, `black_rgb`} and a white fill writes {0xFF, `white_rgb`}.
- R8: A pixel at column x and row y of a surface has byte address base + y × pitch + x × bytes-per-pixel, taken modulo 2^ADDR_W.
- R9: Columns are visited left to right when `x_fwd`=1 and right to left otherwise. Rows are visited top to bottom when `y_fwd`=1 and bottom to top otherwise. In a copy, each pixel is read just before it is written, so overlapping copies follow this order.
- R10: After a copy, `dst_x_out` = left+width if `x_fwd`, else left. `dst_y_out` = top+height if `y_fwd`, else top.
- R11: After a fill, `dst_y_out` follows the R10 rule and `dst_x_out` takes the programmed `dst_x`. After a rejected job, both outputs keep their previous values.
- R12: `busy` is high from the cycle after an accepted `start` until `done`, and `done` is a one-cycle pulse. A `start` that arrives while busy is ignored.
- R13: Once raised, a memory request holds its address, direction and data until `mem_ready` accepts it.
- R14: A job with zero width or zero height makes no memory access, and it still updates the coordinates as in R10/R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| src_x | input | COORD_W | Source anchor column |
| src_y | input | COORD_W | Source anchor row |
| dst_x | input | COORD_W | Destination anchor column |
| dst_y | input | COORD_W | Destination anchor row |
| width | input | DIM_W | Rectangle width in pixels |
| height | input | DIM_W | Rectangle height in pixels |
| src_pitch | input | PITCH_W | Source bytes per row |
| dst_pitch | input | PITCH_W | Destination bytes per row |
| def_pitch | input | PITCH_W | Shared bytes per row |
| src_base | input | ADDR_W | Source surface byte offset |
| dst_base | input | ADDR_W | Destination surface byte offset |
| def_base | input | ADDR_W | Shared surface byte offset |
| per_surface | input | 1 | 1: per-surface pitch/offset, 0: shared |
| x_fwd | input | 1 | 1: left to right |
| y_fwd | input | 1 | 1: top to bottom |
| pix_type | input | 4 | Pixel type code |
| mix | input | 32 | Mix word, raster code in bits 23:16 |
| brush_color | input | 32 | Brush fill colour |
| black_rgb | input | 24 | Black fill colour |
| white_rgb | input | 24 | White fill colour |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_error | output | 1 | Last job rejected by set-up check |
| rop_unsupported | output | 1 | Last job had an unknown raster code |
| dst_x_out | output | COORD_W | Updated destination column |
| dst_y_out | output | COORD_W | Updated destination row |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rdata | input | 32 | Read data, valid with accepted read |

## Verification
The assertions check several rules on every cycle:
- no memory request outside a job, and `done` never lasting longer than one cycle;
- a stalled request holding its address and direction;
- byte enables always forming a contiguous low mask;
- a rejected job never reaching the memory port;
- the captured set-up staying frozen when `start` arrives mid-job;
- the column walker staying inside the rectangle.

Some behaviour can only be shown by the bench's scenarios, which compare the whole frame buffer and the coordinate outputs against an arithmetic model:
- the exact pixels moved in overlapping copies in all four direction pairs, across every pixel size;
- fill colours;
- the boundary cases of the frame-buffer limit;
- the coordinate update rules.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam logic [7:0] ROP_COPY  = 8'hCC;
    localparam logic [7:0] ROP_BRUSH = 8'hF0;
    localparam logic [7:0] ROP_BLACK = 8'h00;
    localparam logic [7:0] ROP_WHITE = 8'hFF;

    localparam logic [31:0] CORNER_MAX = 32'h0000_3FFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ,
        S_WRITE,
        S_FINISH
    } blit_state_t;

    // Bytes per pixel for a type code; zero marks an invalid code.
    function automatic logic [2:0] type_bytes(input logic [3:0] code);
        unique case (code)
            4'd2:       return 3'd1;
            4'd3, 4'd4: return 3'd2;
            4'd5:       return 3'd3;
            4'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] anchor(input logic [31:0] pos,
                                           input logic [31:0] size,
                                           input logic fwd);
        return fwd ? pos : pos + 32'd1 - size;
    endfunction

endpackage

// File: rtl/blit_setup.sv
module blit_setup
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 16,
    parameter int DIM_W   = 14,
    parameter int PITCH_W = 14
) (
    input  logic [COORD_W-1:0] x_src,
    input  logic [COORD_W-1:0] y_src,
    input  logic [COORD_W-1:0] x_dst,
    input  logic [COORD_W-1:0] y_dst,
    input  logic [DIM_W-1:0]   w,
    input  logic [DIM_W-1:0]   h,
    input  logic [PITCH_W-1:0] pitch_s_r,
    input  logic [PITCH_W-1:0] pitch_d_r,
    input  logic [PITCH_W-1:0] pitch_f_r,
    input  logic [ADDR_W-1:0]  off_s_r,
    input  logic [ADDR_W-1:0]  off_d_r,
    input  logic [ADDR_W-1:0]  off_f_r,
    input  logic               per_surf,
    input  logic               xf,
    input  logic               yf,
    input  logic [3:0]         ptype,
    input  logic [7:0]         rop,
    input  logic [31:0]        brush,
    input  logic [23:0]        blk,
    input  logic [23:0]        wht,
    output logic [31:0]        s_left,
    output logic [31:0]        s_top,
    output logic [31:0]        d_left,
    output logic [31:0]        d_top,
    output logic [PITCH_W-1:0] s_pitch,
    output logic [PITCH_W-1:0] d_pitch,
    output logic [ADDR_W-1:0]  s_off,
    output logic [ADDR_W-1:0]  d_off,
    output logic [2:0]         pix_bytes,
    output logic               is_copy,
    output logic [31:0]        fill_px,
    output logic               cfg_bad,
    output logic               rop_bad,
    output logic               empty
);
    localparam int          WIDE  = 48;
    localparam logic [WIDE-1:0] FB_END = WIDE'(1) << ADDR_W;

    logic [WIDE-1:0] s_reach, d_reach;
    logic            d_bad, s_bad;

    always_comb begin
        s_pitch   = per_surf ? pitch_s_r : pitch_f_r;
        d_pitch   = per_surf ? pitch_d_r : pitch_f_r;
        s_off     = per_surf ? off_s_r   : off_f_r;
        d_off     = per_surf ? off_d_r   : off_f_r;
        pix_bytes = type_bytes(ptype);
        s_left    = anchor(32'(x_src), 32'(w), xf);
        s_top     = anchor(32'(y_src), 32'(h), yf);
        d_left    = anchor(32'(x_dst), 32'(w), xf);
        d_top     = anchor(32'(y_dst), 32'(h), yf);
        s_reach   = WIDE'(s_off) + WIDE'(s_left) + (WIDE'(s_top) + WIDE'(h)) * WIDE'(s_pitch);
        d_reach   = WIDE'(d_off) + WIDE'(d_left) + (WIDE'(d_top) + WIDE'(h)) * WIDE'(d_pitch);
        d_bad     = (d_pitch == '0) || (d_left > CORNER_MAX) || (d_top > CORNER_MAX)
                    || (d_reach >= FB_END);
        s_bad     = (s_pitch == '0) || (s_left > CORNER_MAX) || (s_top > CORNER_MAX)
                    || (s_reach >= FB_END);
        is_copy   = (rop == ROP_COPY);
        rop_bad   = !(is_copy || rop == ROP_BRUSH || rop == ROP_BLACK || rop == ROP_WHITE);
        cfg_bad   = (pix_bytes == 3'd0) || d_bad || (is_copy && s_bad);
        empty     = (w == '0) || (h == '0);
        unique case (rop)
            ROP_BLACK: fill_px = {8'hFF, blk};
            ROP_WHITE: fill_px = {8'hFF, wht};
            default:   fill_px = brush;
        endcase
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
    parameter int DIM_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             active,
    input  logic [DIM_W-1:0] w,
    input  logic [DIM_W-1:0] h,
    input  logic             xf,
    input  logic             yf,
    output logic [DIM_W-1:0] col,
    output logic [DIM_W-1:0] row,
    output logic             last
);
    logic [DIM_W-1:0] i_q, j_q;
    logic             row_end;

    assign row_end = (i_q == w - 1'b1);
    assign last    = row_end && (j_q == h - 1'b1);
    assign col     = xf ? i_q : w - 1'b1 - i_q;
    assign row     = yf ? j_q : h - 1'b1 - j_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
            j_q <= '0;
        end else if (load) begin
            i_q <= '0;
            j_q <= '0;
        end else if (step) begin
            if (row_end) begin
                i_q <= '0;
                j_q <= j_q + 1'b1;
            end else begin
                i_q <= i_q + 1'b1;
            end
        end
    end

    AST_WALK_IN_RECT: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (i_q < w) && (j_q < h)); // R9

endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 16,
    parameter int DIM_W   = 14,
    parameter int PITCH_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [PITCH_W-1:0] def_pitch,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [ADDR_W-1:0]  def_base,
    input  logic               per_surface,
    input  logic               x_fwd,
    input  logic               y_fwd,
    input  logic [3:0]         pix_type,
    input  logic [31:0]        mix,
    input  logic [31:0]        brush_color,
    input  logic [23:0]        black_rgb,
    input  logic [23:0]        white_rgb,
    output logic               busy,
    output logic               done,
    output logic               cfg_error,
    output logic               rop_unsupported,
    output logic [COORD_W-1:0] dst_x_out,
    output logic [COORD_W-1:0] dst_y_out,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ready,
    input  logic [31:0]        mem_rdata
);
    localparam int WIDE = 48;

    typedef struct packed {
        logic [COORD_W-1:0] sx, sy, dx, dy;
        logic [DIM_W-1:0]   w, h;
        logic [PITCH_W-1:0] sp, dp, fp;
        logic [ADDR_W-1:0]  sb, db, fb;
        logic               per, xf, yf;
        logic [3:0]         ty;
        logic [7:0]         rop;
        logic [31:0]        brush;
        logic [23:0]        blk, wht;
    } cfg_t;

    blit_state_t state_q, state_d;
    cfg_t        cfg_q;
    logic [31:0] pix_q;

    logic [31:0]        s_left, s_top, d_left, d_top, fill_px;
    logic [PITCH_W-1:0] s_pitch, d_pitch;
    logic [ADDR_W-1:0]  s_off, d_off;
    logic [2:0]         pix_bytes;
    logic               is_copy, cfg_bad, rop_bad, empty;
    logic [DIM_W-1:0]   col, row;
    logic               last, accept_start, last_write, finish_ok;
    logic [WIDE-1:0]    s_lin, d_lin;

    blit_setup #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_setup (
        .x_src(cfg_q.sx), .y_src(cfg_q.sy), .x_dst(cfg_q.dx), .y_dst(cfg_q.dy),
        .w(cfg_q.w), .h(cfg_q.h),
        .pitch_s_r(cfg_q.sp), .pitch_d_r(cfg_q.dp), .pitch_f_r(cfg_q.fp),
        .off_s_r(cfg_q.sb), .off_d_r(cfg_q.db), .off_f_r(cfg_q.fb),
        .per_surf(cfg_q.per), .xf(cfg_q.xf), .yf(cfg_q.yf), .ptype(cfg_q.ty),
        .rop(cfg_q.rop), .brush(cfg_q.brush), .blk(cfg_q.blk), .wht(cfg_q.wht),
        .s_left(s_left), .s_top(s_top), .d_left(d_left), .d_top(d_top),
        .s_pitch(s_pitch), .d_pitch(d_pitch), .s_off(s_off), .d_off(d_off),
        .pix_bytes(pix_bytes), .is_copy(is_copy), .fill_px(fill_px),
        .cfg_bad(cfg_bad), .rop_bad(rop_bad), .empty(empty)
    );

    blit_walker #(.DIM_W(DIM_W)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == S_CHECK),
        .step(state_q == S_WRITE && mem_ready),
        .active(state_q == S_READ || state_q == S_WRITE),
        .w(cfg_q.w), .h(cfg_q.h), .xf(cfg_q.xf), .yf(cfg_q.yf),
        .col(col), .row(row), .last(last)
    );

    assign accept_start = (state_q == S_IDLE) && start;
    assign last_write   = (state_q == S_WRITE) && mem_ready && last;
    assign finish_ok    = last_write || (state_q == S_CHECK && !cfg_bad && !rop_bad && empty);

    always_comb begin
        s_lin = WIDE'(s_off) + (WIDE'(s_top) + WIDE'(row)) * WIDE'(s_pitch)
                + (WIDE'(s_left) + WIDE'(col)) * WIDE'(pix_bytes);
        d_lin = WIDE'(d_off) + (WIDE'(d_top) + WIDE'(row)) * WIDE'(d_pitch)
                + (WIDE'(d_left) + WIDE'(col)) * WIDE'(pix_bytes);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_CHECK;
            S_CHECK: begin
                if (cfg_bad || rop_bad || empty) state_d = S_FINISH;
                else if (is_copy)                state_d = S_READ;
                else                             state_d = S_WRITE;
            end
            S_READ:   if (mem_ready) state_d = S_WRITE;
            S_WRITE: begin
                if (mem_ready) begin
                    if (last)         state_d = S_FINISH;
                    else if (is_copy) state_d = S_READ;
                    else              state_d = S_WRITE;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        mem_req   = (state_q == S_READ) || (state_q == S_WRITE);
        mem_we    = (state_q == S_WRITE);
        mem_addr  = ADDR_W'((state_q == S_READ) ? s_lin : d_lin);
        mem_be    = 4'((5'd1 << pix_bytes) - 5'd1);
        mem_wdata = is_copy ? pix_q : fill_px;
    end

    // Captured set-up, fetched pixel, status and coordinates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q           <= '0;
            pix_q           <= '0;
            cfg_error       <= 1'b0;
            rop_unsupported <= 1'b0;
            dst_x_out       <= '0;
            dst_y_out       <= '0;
        end else begin
            if (accept_start) begin
                cfg_q           <= '{sx: src_x, sy: src_y, dx: dst_x, dy: dst_y,
                                     w: width, h: height,
                                     sp: src_pitch, dp: dst_pitch, fp: def_pitch,
                                     sb: src_base, db: dst_base, fb: def_base,
                                     per: per_surface, xf: x_fwd, yf: y_fwd,
                                     ty: pix_type, rop: mix[23:16], brush: brush_color,
                                     blk: black_rgb, wht: white_rgb};
                cfg_error       <= 1'b0;
                rop_unsupported <= 1'b0;
            end
            if (state_q == S_CHECK) begin
                cfg_error       <= cfg_bad;
                rop_unsupported <= rop_bad;
            end
            if (state_q == S_READ && mem_ready) pix_q <= mem_rdata;
            if (finish_ok) begin
                if (is_copy)
                    dst_x_out <= COORD_W'(cfg_q.xf ? d_left + 32'(cfg_q.w) : d_left);
                else
                    dst_x_out <= cfg_q.dx;
                dst_y_out <= COORD_W'(cfg_q.yf ? d_top + 32'(cfg_q.h) : d_top);
            end
        end
    end

    AST_REQ_INSIDE_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cfg_q)); // R12
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $onehot({1'b0, mem_be} + 5'd1)); // R1
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && (cfg_bad || rop_bad)) |=> !mem_req && done); // R5

endmodule

// File: tb/tb_blit2d_engine.sv
module tb_blit2d_engine;
    localparam int AW = 12;
    localparam int FB = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 1'b0;
    logic [15:0] sx, sy, dx, dy;
    logic [13:0] w, h, sp, dp, fp;
    logic [AW-1:0] sb, db, fb;
    logic        per, xf, yf, stall;
    logic [3:0]  ty;
    logic [31:0] mix, brush;
    logic [23:0] blk, wht;
    logic        busy, done, cerr, cuns, mem_req, mem_we, mem_ready;
    logic [15:0] xo, yo;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;

    blit2d_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_x(sx), .src_y(sy), .dst_x(dx), .dst_y(dy), .width(w), .height(h),
        .src_pitch(sp), .dst_pitch(dp), .def_pitch(fp),
        .src_base(sb), .dst_base(db), .def_base(fb),
        .per_surface(per), .x_fwd(xf), .y_fwd(yf), .pix_type(ty), .mix(mix),
        .brush_color(brush), .black_rgb(blk), .white_rgb(wht),
        .busy(busy), .done(done), .cfg_error(cerr), .rop_unsupported(cuns),
        .dst_x_out(xo), .dst_y_out(yo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [FB];
    logic [7:0] exp_mem [FB];
    int cyc = 0, wr_count = 0, mark = 0;
    logic [AW-1:0] first_wa;
    int checks = 0, fails = 0;
    int exp_xo = 0, exp_yo = 0, exp_first = 0;

    assign mem_ready = !stall || (cyc % 3 != 1);
    assign mem_rdata = {mem[mem_addr + 12'd3], mem[mem_addr + 12'd2],
                        mem[mem_addr + 12'd1], mem[mem_addr]};

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_req && mem_we && mem_ready) begin
            if (wr_count == mark) first_wa = mem_addr;
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr + 12'(b)] = mem_wdata[8*b +: 8];
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int bytes_of(input logic [3:0] c);
        case (c)
            4'd2: return 1;
            4'd3, 4'd4: return 2;
            4'd5: return 3;
            4'd6: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic pattern(input int seed);
        for (int i = 0; i < FB; i++) begin
            mem[i] = 8'(i * 13 + seed);
            exp_mem[i] = mem[i];
        end
    endtask

    // Places the rectangle by its resolved left/top corner for the given directions
    task automatic geom(input int code, input bit xv, input bit yv, input int sl, input int st,
                        input int dl, input int dt, input int wv, input int hv);
        ty = 4'(code); xf = xv; yf = yv; w = 14'(wv); h = 14'(hv);
        sx = 16'(xv ? sl : sl + wv - 1); sy = 16'(yv ? st : st + hv - 1);
        dx = 16'(xv ? dl : dl + wv - 1); dy = 16'(yv ? dt : dt + hv - 1);
    endtask

    // Arithmetic model of the requirements, applied to exp_mem
    task automatic model();
        int bp, spv, dpv, sbv, dbv, dl, dt, sl, st, c, r, da, sa;
        logic [31:0] px, fillv;
        bit copy;
        bp  = bytes_of(ty);
        spv = per ? int'(sp) : int'(fp);  dpv = per ? int'(dp) : int'(fp);
        sbv = per ? int'(sb) : int'(fb);  dbv = per ? int'(db) : int'(fb);
        dl = xf ? int'(dx) : int'(dx) + 1 - int'(w);
        dt = yf ? int'(dy) : int'(dy) + 1 - int'(h);
        sl = xf ? int'(sx) : int'(sx) + 1 - int'(w);
        st = yf ? int'(sy) : int'(sy) + 1 - int'(h);
        copy = (mix[23:16] == 8'hCC);
        fillv = (mix[23:16] == 8'h00) ? {8'hFF, blk} :
                (mix[23:16] == 8'hFF) ? {8'hFF, wht} : brush;
        exp_first = -1;
        for (int j = 0; j < int'(h); j++) begin
            for (int i = 0; i < int'(w); i++) begin
                r = yf ? j : int'(h) - 1 - j;
                c = xf ? i : int'(w) - 1 - i;
                da = (dbv + (dt + r) * dpv + (dl + c) * bp) % FB;
                if (exp_first < 0) exp_first = da;
                if (copy) begin
                    sa = (sbv + (st + r) * spv + (sl + c) * bp) % FB;
                    for (int b = 0; b < 4; b++) px[8*b +: 8] = exp_mem[(sa + b) % FB];
                end else px = fillv;
                for (int b = 0; b < bp; b++) exp_mem[(da + b) % FB] = px[8*b +: 8];
            end
        end
        exp_xo = copy ? (xf ? dl + int'(w) : dl) : int'(dx);
        exp_yo = yf ? dt + int'(h) : dt;
        exp_xo = exp_xo & 16'hFFFF; exp_yo = exp_yo & 16'hFFFF;
    endtask

    task automatic launch();
        mark = wr_count;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    function automatic int mism();
        int n = 0;
        for (int i = 0; i < FB; i++) if (mem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    task automatic good(input string tag);
        model();
        launch();
        chk({tag, " frame buffer image"}, mism(), 0);
        chk({tag, " R10 R11 x out"}, xo, exp_xo);
        chk({tag, " R10 R11 y out"}, yo, exp_yo);
        chk({tag, " R6 flags"}, {cerr, cuns}, 0);
        chk({tag, " R14 write count"}, wr_count - mark, int'(w) * int'(h));
        if (int'(w) * int'(h) > 0) chk({tag, " R9 first write address"}, first_wa, exp_first);
    endtask

    task automatic bad(input string tag, input bit e_err, input bit e_uns);
        int px_, py_;
        px_ = xo; py_ = yo;
        launch();
        chk({tag, " flags"}, {cerr, cuns}, {e_err, e_uns});
        chk({tag, " nothing written"}, wr_count - mark, 0);
        chk({tag, " R11 x kept"}, xo, px_);
        chk({tag, " R11 y kept"}, yo, py_);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        per = 1; sp = 64; dp = 64; fp = 0; sb = 256; db = 256; fb = 0;
        mix = 32'h00CC0000; brush = 32'hA1B2C3D4; blk = 24'h102030; wht = 24'hE0D0C0;
        stall = 0; geom(6, 1, 1, 0, 0, 0, 0, 1, 1);
        repeat (3) @(negedge clk);
        chk("R12 reset busy", busy, 0);
        chk("R12 reset done", done, 0);
        chk("R13 reset no request", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Overlapping copies, every type code and direction pair
        for (int code = 2; code <= 6; code++) begin
            for (int d = 0; d < 4; d++) begin
                pattern(code * 4 + d);
                stall = d[0] ^ code[0];
                geom(code, d[0], d[1], 2, 1, 3, 2, 5, 3);
                good($sformatf("R1 R2 R8 R9 copy type=%0d dir=%0d", code, d));
            end
        end

        // Shared pitch/offset, per-surface ones set to zero
        pattern(91); per = 0; fp = 40; fb = 100; sp = 0; dp = 0;
        geom(6, 1, 1, 1, 1, 4, 12, 3, 2);
        good("R3 shared pitch copy");
        // Distinct per-surface bases and pitches
        pattern(92); per = 1; sp = 30; sb = 50; dp = 48; db = 2000;
        geom(3, 0, 1, 2, 3, 5, 1, 4, 3);
        good("R3 per-surface copy");

        // Fills
        pattern(93); sp = 0; dp = 64; db = 256; mix = 32'h00F00000;
        geom(6, 0, 0, 0, 0, 4, 4, 3, 2);
        good("R4 R7 brush fill ignores source pitch");
        pattern(94); mix = 32'h00000000;
        geom(6, 1, 0, 0, 0, 1, 6, 2, 2);
        good("R7 black fill");
        pattern(95); mix = 32'h00FF0000;
        geom(5, 0, 1, 0, 0, 7, 1, 3, 3);
        good("R7 white fill 24bpp");

        // Rejections
        pattern(96); mix = 32'h00CC0000; sp = 64;
        geom(7, 1, 1, 0, 0, 1, 1, 2, 2);
        bad("R1 invalid type", 1, 0);
        geom(6, 1, 1, 0, 0, 1, 1, 2, 2); dp = 0;
        bad("R4 zero destination pitch", 1, 0);
        dp = 64; sp = 0;
        bad("R4 zero source pitch copy", 1, 0);
        sp = 64; geom(2, 1, 1, 0, 0, 0, 0, 2, 2); dx = 16'h4000;
        bad("R5 corner above limit", 1, 0);
        geom(2, 0, 1, 0, 0, 0, 0, 5, 1); dx = 16'd1; sx = 16'd8;
        bad("R2 R5 reverse corner below zero", 1, 0);
        sb = 0; db = 0; geom(2, 1, 1, 0, 0, 64, 60, 1, 3);
        bad("R5 frame buffer end reached", 1, 0);
        mix = 32'h66000000 | 32'h00660000;
        geom(2, 1, 1, 0, 0, 1, 1, 2, 2);
        bad("R6 unsupported raster code", 0, 1);
        chk("R6 image untouched", mism(), 0);

        // Just inside the frame buffer end
        mix = 32'h00CC0000; geom(2, 1, 1, 0, 0, 63, 60, 1, 3);
        good("R5 last column inside limit");

        // Empty rectangles
        sb = 256; db = 256; geom(6, 1, 1, 5, 5, 5, 5, 0, 2);
        good("R14 zero width copy");
        mix = 32'h00F00000; geom(6, 0, 0, 0, 0, 9, 9, 3, 0);
        good("R14 zero height fill");

        // Start pulses while busy are ignored
        pattern(97); mix = 32'h00CC0000; stall = 1;
        geom(6, 1, 1, 0, 0, 8, 3, 6, 3);
        model();
        mark = wr_count;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R12 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        dx = 16'd30; dy = 16'd20; start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        chk("R12 ignored start image", mism(), 0);
        chk("R12 ignored start x out", xo, exp_xo);
        @(negedge clk);
        chk("R12 done one cycle", done, 0);
        chk("R12 idle after done", busy, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule